// File: doc/BRIEF.md
# Container Queue with Random-Access Active Slots

This block carries fixed-size data containers from one producer process to one consumer process in first-in first-out order. Each side owns one active container at a time and reaches any word in it through its own port, using an operation code, a word address, write data and read data. Words can be written in one order and read in another, for example a zigzag scan. Either side may also use its active container as scratch space.

When the producer has filled its active container, fully or only in part, it issues a commit. That hands the container to the queue and moves the producer on to the next free slot. When the consumer has finished with the container at the head of the queue, its commit frees that slot. A full flag tells the producer that no free container is left, and an empty flag tells the consumer that none is waiting. Both sides therefore stall on a flag rather than on any per-word handshake. The number of containers and the words per container are parameters. With one word per container the block acts as a plain word FIFO.

Top module: `cq_top`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0 and `fault` is 0.
- R2: Each port takes a 2-bit code: 2'b00 does nothing, 2'b01 reads the word at the port address, 2'b10 writes the port data to that address, and 2'b11 commits the active container.
- R3: The producer may write words of its active container in any address order. Before committing, it may read back any word it has written.
- R4: A producer commit makes the container visible: `empty` drops in the cycle after the commit, and the consumer then reads each committed word at its own address, in any order.
- R5: Containers reach the consumer in the order they were committed. Slot pointers wrap modulo the container count, so more than that many containers can pass through in sequence.
- R6: After as many unreleased producer commits as there are containers, `full` is 1. One consumer commit clears `full` in the following cycle.
- R7: A producer write or commit while `full` is 1 has no effect. A consumer read, write or commit while `empty` is 1 has no effect. Each such attempt sets `fault`, which then stays 1 until reset.
- R8: A container may be committed with only some of its words written, and the consumer reads those words correctly.
- R9: The consumer may write words into its active container and read them back before releasing it.
- R10: A producer commit and a consumer commit in the same cycle, with neither blocked, leave `full` and `empty` unchanged and advance both sides.
- R11: Read data appears on the port one cycle after the read operation and holds its value until the next read that takes effect on that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prod_op | input | 2 | Producer operation code |
| prod_addr | input | WORD_AW | Word address in the producer's active container |
| prod_wdata | input | DATA_W | Producer write data |
| prod_rdata | output | DATA_W | Producer read data, registered |
| full | output | 1 | No free container is left for the producer |
| cons_op | input | 2 | Consumer operation code |
| cons_addr | input | WORD_AW | Word address in the consumer's active container |
| cons_wdata | input | DATA_W | Consumer write data |
| cons_rdata | output | DATA_W | Consumer read data, registered |
| empty | output | 1 | No committed container is waiting for the consumer |
| fault | output | 1 | Sticky flag for an operation that was blocked |

## Verification
The assertions assume that the operation codes are never unknown after reset and that the two sides touch distinct slots whenever the queue is neither full nor empty, which follows from the pointer arithmetic. The stimulus drives one well-defined code per port in every cycle and returns both ports to no-operation between steps. Blocked operations are issued on purpose, and the bench then checks that the flags, the sticky fault and the data later read out show no trace of them.

// File: rtl/cq_pkg.sv
package cq_pkg;
  typedef enum logic [1:0] {
    CQ_IDLE   = 2'b00,
    CQ_READ   = 2'b01,
    CQ_WRITE  = 2'b10,
    CQ_COMMIT = 2'b11
  } cq_op_e;
endpackage

// File: rtl/cq_store.sv
module cq_store #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 16,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic              a_re,
  input  logic [AW-1:0]     a_addr,
  input  logic [DATA_W-1:0] a_wd,
  output logic [DATA_W-1:0] a_rd,
  input  logic              b_we,
  input  logic              b_re,
  input  logic [AW-1:0]     b_addr,
  input  logic [DATA_W-1:0] b_wd,
  output logic [DATA_W-1:0] b_rd
);
  logic [DATA_W-1:0] mem [DEPTH];

  // dual-port RAM, read-first, registered read data held when idle
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wd;
    if (b_we) mem[b_addr] <= b_wd;
    if (a_re) a_rd <= mem[a_addr];
    if (b_re) b_rd <= mem[b_addr];
  end

  // R7: the gating upstream must keep the two sides off the same word
  a_r7_no_shared_write: assert property (@(posedge clk)
    (a_we && b_we) |-> (a_addr != b_addr));
endmodule

// File: rtl/cq_ctrl.sv
module cq_ctrl
  import cq_pkg::*;
#(
  parameter int NUM_BLK = 4,
  parameter int PTR_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       prod_op,
  input  logic [1:0]       cons_op,
  output logic [PTR_W-1:0] prod_ptr,
  output logic [PTR_W-1:0] cons_ptr,
  output logic             prod_we,
  output logic             prod_re,
  output logic             cons_we,
  output logic             cons_re,
  output logic             full,
  output logic             empty,
  output logic             fault
);
  localparam int CNT_W = $clog2(NUM_BLK + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NUM_BLK);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_BLK - 1);

  logic [CNT_W-1:0] held, held_nx;
  logic             p_cmt, c_cmt, p_bad, c_bad;

  always_comb begin
    prod_re = (prod_op == CQ_READ);
    prod_we = (prod_op == CQ_WRITE)  && !full;
    p_cmt   = (prod_op == CQ_COMMIT) && !full;
    p_bad   = ((prod_op == CQ_WRITE) || (prod_op == CQ_COMMIT)) && full;
    cons_re = (cons_op == CQ_READ)   && !empty;
    cons_we = (cons_op == CQ_WRITE)  && !empty;
    c_cmt   = (cons_op == CQ_COMMIT) && !empty;
    c_bad   = (cons_op != CQ_IDLE)   && empty;
    held_nx = held;
    if (p_cmt && !c_cmt) held_nx = held + 1'b1;
    if (c_cmt && !p_cmt) held_nx = held - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_ptr <= '0;
      cons_ptr <= '0;
      held     <= '0;
      full     <= 1'b0;
      empty    <= 1'b1;
      fault    <= 1'b0;
    end else begin
      if (p_cmt) prod_ptr <= (prod_ptr == PTR_LAST) ? '0 : prod_ptr + 1'b1;
      if (c_cmt) cons_ptr <= (cons_ptr == PTR_LAST) ? '0 : cons_ptr + 1'b1;
      held  <= held_nx;
      full  <= (held_nx == CNT_MAX);
      empty <= (held_nx == '0);
      if (p_bad || c_bad) fault <= 1'b1;
    end
  end

  // R1/R6: the flags never contradict each other
  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
  // R4: an accepted producer commit without a release clears empty
  a_r4_commit_shows: assert property (@(posedge clk) disable iff (rst)
    (!full && prod_op == CQ_COMMIT && cons_op != CQ_COMMIT) |=> !empty);
  // R7: a commit while full does not change the state
  a_r7_full_holds: assert property (@(posedge clk) disable iff (rst)
    (full && cons_op != CQ_COMMIT) |=> (full && $stable(prod_ptr)));
  // R7: a release while empty does not change the state
  a_r7_empty_holds: assert property (@(posedge clk) disable iff (rst)
    (empty && prod_op != CQ_COMMIT) |=> (empty && $stable(cons_ptr)));
  // R7: the fault flag is sticky
  a_r7_fault_sticky: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault);
  // R10: commits on both sides in one cycle keep the flags
  a_r10_dual_commit: assert property (@(posedge clk) disable iff (rst)
    (!full && !empty && prod_op == CQ_COMMIT && cons_op == CQ_COMMIT)
      |=> (!full && !empty));
  // R6: occupancy never exceeds the container count
  a_r6_held_bound: assert property (@(posedge clk) disable iff (rst)
    held <= CNT_MAX);
endmodule

// File: rtl/cq_top.sv
module cq_top #(
  parameter int NUM_BLK   = 4,
  parameter int BLK_WORDS = 16,
  parameter int DATA_W    = 16,
  parameter int WORD_AW   = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         prod_op,
  input  logic [WORD_AW-1:0] prod_addr,
  input  logic [DATA_W-1:0]  prod_wdata,
  output logic [DATA_W-1:0]  prod_rdata,
  output logic               full,
  input  logic [1:0]         cons_op,
  input  logic [WORD_AW-1:0] cons_addr,
  input  logic [DATA_W-1:0]  cons_wdata,
  output logic [DATA_W-1:0]  cons_rdata,
  output logic               empty,
  output logic               fault
);
  localparam int PTR_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;
  localparam int DEPTH  = NUM_BLK * BLK_WORDS;
  localparam int MEM_AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam bit POW2   = (BLK_WORDS > 1) && ((BLK_WORDS & (BLK_WORDS - 1)) == 0);

  logic [PTR_W-1:0]  p_ptr, c_ptr;
  logic              p_we, p_re, c_we, c_re;
  logic [MEM_AW-1:0] p_maddr, c_maddr;

  cq_ctrl #(.NUM_BLK(NUM_BLK), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rst(rst), .prod_op(prod_op), .cons_op(cons_op),
    .prod_ptr(p_ptr), .cons_ptr(c_ptr),
    .prod_we(p_we), .prod_re(p_re), .cons_we(c_we), .cons_re(c_re),
    .full(full), .empty(empty), .fault(fault)
  );

  // slot base plus word offset; concatenation when the slot size is a power of two
  generate
    if (POW2) begin : g_concat
      assign p_maddr = MEM_AW'({p_ptr, prod_addr[WORD_AW-1:0]});
      assign c_maddr = MEM_AW'({c_ptr, cons_addr[WORD_AW-1:0]});
    end else begin : g_mult
      assign p_maddr = MEM_AW'(p_ptr) * MEM_AW'(BLK_WORDS) + MEM_AW'(prod_addr);
      assign c_maddr = MEM_AW'(c_ptr) * MEM_AW'(BLK_WORDS) + MEM_AW'(cons_addr);
    end
  endgenerate

  cq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(MEM_AW)) u_store (
    .clk(clk),
    .a_we(p_we), .a_re(p_re), .a_addr(p_maddr), .a_wd(prod_wdata), .a_rd(prod_rdata),
    .b_we(c_we), .b_re(c_re), .b_addr(c_maddr), .b_wd(cons_wdata), .b_rd(cons_rdata)
  );
endmodule

// File: tb/tb_cq_top.sv
module tb_cq_top;
  localparam int NB = 4;
  localparam int NW = 16;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam logic [1:0] NOP = 2'b00, RD = 2'b01, WR = 2'b10, CM = 2'b11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    prod_op = NOP, cons_op = NOP;
  logic [AW-1:0] prod_addr = '0, cons_addr = '0;
  logic [DW-1:0] prod_wdata = '0, cons_wdata = '0;
  logic [DW-1:0] prod_rdata, cons_rdata;
  logic          full, empty, fault;
  int vecs = 0, bad = 0;

  always #10 clk = ~clk;

  cq_top #(.NUM_BLK(NB), .BLK_WORDS(NW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst),
    .prod_op(prod_op), .prod_addr(prod_addr), .prod_wdata(prod_wdata),
    .prod_rdata(prod_rdata), .full(full),
    .cons_op(cons_op), .cons_addr(cons_addr), .cons_wdata(cons_wdata),
    .cons_rdata(cons_rdata), .empty(empty), .fault(fault)
  );

  task automatic check(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: apply ops, wait for the edge, then park both ports on NOP
  task automatic step(input logic [1:0] po, input int pa, input int pd,
                      input logic [1:0] co, input int ca, input int cd);
    prod_op = po; prod_addr = AW'(pa); prod_wdata = DW'(pd);
    cons_op = co; cons_addr = AW'(ca); cons_wdata = DW'(cd);
    @(negedge clk);
    prod_op = NOP; cons_op = NOP;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 empty", int'(empty), 1);
    check("R1 full", int'(full), 0);
    check("R1 fault", int'(fault), 0);
  endtask

  task automatic t_random_access();
    do_reset();
    for (int i = NW - 1; i >= 0; i--) step(WR, i, 300 + 7 * i, NOP, 0, 0);
    step(RD, 5, 0, NOP, 0, 0);
    check("R3 producer readback", int'(prod_rdata), 335);
    check("R4 empty before commit", int'(empty), 1);
    step(CM, 0, 0, NOP, 0, 0);
    check("R4 empty after commit", int'(empty), 0);
    for (int k = 0; k < NW; k++) begin
      int a = (k * 5) % NW;
      step(NOP, 0, 0, RD, a, 0);
      check("R4 consumer word", int'(cons_rdata), 300 + 7 * a);
    end
    step(NOP, 0, 0, NOP, 0, 0);
    check("R11 rdata holds", int'(cons_rdata), 300 + 7 * ((5 * (NW - 1)) % NW));
    step(NOP, 0, 0, CM, 0, 0);
    check("R4 empty after release", int'(empty), 1);
  endtask

  task automatic t_order_full();
    do_reset();
    for (int b = 0; b < NB; b++) begin
      step(WR, 0, 100 + b, NOP, 0, 0);
      step(CM, 0, 0, NOP, 0, 0);
    end
    check("R6 full", int'(full), 1);
    check("R6 not empty", int'(empty), 0);
    step(WR, 0, 999, NOP, 0, 0);
    step(CM, 0, 0, NOP, 0, 0);
    check("R7 full stays", int'(full), 1);
    check("R7 fault set", int'(fault), 1);
    for (int b = 0; b < NB; b++) begin
      step(NOP, 0, 0, RD, 0, 0);
      check("R5 order", int'(cons_rdata), 100 + b);
      step(NOP, 0, 0, CM, 0, 0);
      if (b == 0) check("R6 full clears", int'(full), 0);
    end
    check("R5 drained", int'(empty), 1);
    for (int b = 0; b < 2; b++) begin
      step(WR, 2, 500 + b, NOP, 0, 0);
      step(CM, 0, 0, NOP, 0, 0);
    end
    for (int b = 0; b < 2; b++) begin
      step(NOP, 0, 0, RD, 2, 0);
      check("R5 wrap order", int'(cons_rdata), 500 + b);
      step(NOP, 0, 0, CM, 0, 0);
    end
    check("R7 fault sticky", int'(fault), 1);
  endtask

  task automatic t_empty_block();
    do_reset();
    step(WR, 1, 42, NOP, 0, 0);
    step(CM, 0, 0, NOP, 0, 0);
    step(NOP, 0, 0, RD, 1, 0);
    check("R2 read code", int'(cons_rdata), 42);
    step(NOP, 0, 0, CM, 0, 0);
    check("R7 fault clear", int'(fault), 0);
    step(NOP, 0, 0, RD, 1, 0);
    check("R7 read while empty ignored", int'(cons_rdata), 42);
    step(NOP, 0, 0, WR, 1, 77);
    step(NOP, 0, 0, CM, 0, 0);
    check("R7 empty stays", int'(empty), 1);
    check("R7 fault on empty", int'(fault), 1);
    step(WR, 3, 11, NOP, 0, 0);
    step(CM, 0, 0, NOP, 0, 0);
    step(NOP, 0, 0, RD, 3, 0);
    check("R7 next container intact", int'(cons_rdata), 11);
  endtask

  task automatic t_partial_scratch();
    do_reset();
    step(WR, 9, 1234, NOP, 0, 0);
    step(WR, 2, 4321, NOP, 0, 0);
    step(CM, 0, 0, NOP, 0, 0);
    step(NOP, 0, 0, RD, 2, 0);
    check("R8 partial word a", int'(cons_rdata), 4321);
    step(NOP, 0, 0, RD, 9, 0);
    check("R8 partial word b", int'(cons_rdata), 1234);
    step(NOP, 0, 0, WR, 6, 888);
    step(NOP, 0, 0, RD, 6, 0);
    check("R9 consumer scratch", int'(cons_rdata), 888);
    check("R9 fault clear", int'(fault), 0);
  endtask

  task automatic t_dual_commit();
    do_reset();
    step(WR, 0, 61, NOP, 0, 0);
    step(CM, 0, 0, NOP, 0, 0);
    step(WR, 0, 62, NOP, 0, 0);
    step(CM, 0, 0, CM, 0, 0);
    check("R10 not empty", int'(empty), 0);
    check("R10 not full", int'(full), 0);
    step(NOP, 0, 0, RD, 0, 0);
    check("R10 next container", int'(cons_rdata), 62);
    step(NOP, 0, 0, CM, 0, 0);
    check("R10 drained", int'(empty), 1);
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_random_access();
    t_order_full();
    t_empty_block();
    t_partial_scratch();
    t_dual_commit();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule